// File: doc/BRIEF.md
# Three-Phase Time-Delayed Overcurrent Trip Element

This block times overcurrent on three phases and issues a trip once a phase has stayed above its pickup level long enough. On each sampling tick an upstream stage presents one current magnitude per phase, plus a flag per phase that marks inrush. Each phase keeps its own timing accumulator. On inverse-time curves the accumulator advances by a rate that depends on how far the current exceeds the pickup level. On definite-time it advances by one per tick. The characteristic is complete when the accumulator reaches its threshold. A minimum-operate-time floor then applies, and after it a follower delay. Only then does the trip assert.

The configuration selects the curve family and the reset behaviour. Under a definite reset the accumulated time is held for a programmable number of ticks. Under a decaying reset it is drained at a fixed rate, but only on the second curve family; on the other curves that reset clears the time at once. The element can be gated off in three ways: an inhibit input, an enable bit, and a per-phase inrush block. A general pickup output reports whether any phase is picked up.

Top module: `ovc_trip_element`

## Requirements
- R1: Phase p is picked up (`pickup_o[p]`) only when its current is strictly greater than `pickup_lvl_i`. A current equal to the level is not picked up. `gen_pickup_o` is high exactly when any phase is picked up.
- R2: `char_sel_i` selects the curve: 0 = first inverse family, 1 = second inverse family, 2 = user curve, 3 = definite time. The ratio bin is b = min(floor(I/level), 8) − 1. The per-tick rates are:
  - code 0: b+1;
  - code 1: (b+1)²;
  - code 2: byte b of `user_rates_i`, at bits [8b+7:8b].
- R3: The threshold is `tmult_i`·64 on inverse curves. On definite time it is `dt_delay_i`, the rate is 1 and `tmult_i` has no effect. With constant current, the trip is first seen after picked-up tick max(ceil(thr/rate), `min_op_i`, 1) + `follow_i`.
- R4: No trip before `min_op_i` consecutive picked-up ticks, even when the curve completes sooner. The floor never lengthens a curve that is already longer.
- R5: After the characteristic and the floor are satisfied, the trip asserts `follow_i` ticks later.
- R6: With `rst_mode_i`=0, ticks below pickup leave the accumulated time unchanged. It clears on the `rst_delay_i`-th consecutive such tick; a delay of 0 acts as 1.
- R7: With `rst_mode_i`=1 on curve code 1, each tick below pickup lowers the accumulator by 2, floored at 0. With `rst_mode_i`=1 on any other curve, the first tick below pickup clears it.
- R8: `inhibit_i` forces all pickups, trips and the general pickup low in the same cycle. A tick taken while inhibited clears all timing.
- R9: With `inrush_blk_i`=1, a phase whose `inrush_i` bit is set is not picked up and cannot trip. With `inrush_blk_i`=0, the inrush flags have no effect.
- R10: With `enable_i`=0, all outputs are low and a tick clears all timing.
- R11: A trip stays high while its phase remains picked up. It drops at once when the phase falls below pickup. It stays low after a tick taken below pickup until the characteristic times out again. After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sampling tick, one cycle wide |
| cur_i | input | 36 | Phase currents, phase p at [12p+11:12p] |
| inrush_i | input | 3 | Inrush detected, per phase |
| inhibit_i | input | 1 | External inhibit |
| enable_i | input | 1 | Element enable |
| inrush_blk_i | input | 1 | 1 = inrush flags block their phase |
| char_sel_i | input | 2 | Curve select |
| rst_mode_i | input | 1 | 0 = definite reset, 1 = decaying reset |
| pickup_lvl_i | input | 12 | Pickup level |
| tmult_i | input | 8 | Time multiplier |
| dt_delay_i | input | 12 | Definite-time delay in ticks |
| rst_delay_i | input | 12 | Definite reset delay in ticks |
| min_op_i | input | 12 | Minimum operate time in ticks |
| follow_i | input | 12 | Follower delay in ticks |
| user_rates_i | input | 64 | User curve rates, eight bytes |
| pickup_o | output | 3 | Per-phase pickup |
| trip_o | output | 3 | Per-phase trip |
| gen_pickup_o | output | 1 | Any phase picked up |

## Verification
Two things can settle on the same tick: the curve reaching its threshold and the minimum-operate floor. Which one ends the timing decides the trip tick. The bench provokes both orders. A fast second-family curve, which completes in one tick, is run with a ten-tick floor. A slow first-family curve is run with the same floor. Each run is then repeated with a follower delay added. Every run counts ticks from a cleared state until the trip appears and compares the count with max(curve, floor, 1) + follower, computed arithmetically in the bench. A second clash is an inhibit arriving while a trip is held; the bench checks that the trip drops in that same cycle.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
  typedef enum logic [1:0] {
    CH_INV_A = 2'd0,
    CH_INV_B = 2'd1,
    CH_USER  = 2'd2,
    CH_DEF   = 2'd3
  } char_e;

  typedef enum logic {
    RM_HOLD  = 1'b0,
    RM_DECAY = 1'b1
  } rst_mode_e;
endpackage

// File: rtl/ovc_ratio_bin.sv
module ovc_ratio_bin #(
  parameter int CUR_W = 12,
  parameter int NBIN  = 8,
  localparam int BIN_W = $clog2(NBIN)
) (
  input  logic [CUR_W-1:0] cur_i,
  input  logic [CUR_W-1:0] lvl_i,
  output logic             above_o,
  output logic [BIN_W-1:0] bin_o
);
  localparam int PW = CUR_W + $clog2(NBIN + 1);

  logic [NBIN-2:0] ge;

  assign above_o = cur_i > lvl_i;

  // ge[k-2]: current at least k times the level
  for (genvar k = 2; k <= NBIN; k++) begin : g_cmp
    logic [PW-1:0] prod;
    assign prod       = PW'(lvl_i) * PW'(k);
    assign ge[k-2]    = PW'(cur_i) >= prod;
  end

  always_comb begin
    bin_o = '0;
    for (int j = 0; j < NBIN - 1; j++) bin_o = bin_o + BIN_W'(ge[j]);
  end
endmodule

// File: rtl/ovc_rate_lut.sv
module ovc_rate_lut import ovc_pkg::*; #(
  parameter int NBIN   = 8,
  parameter int RATE_W = 8,
  localparam int BIN_W = $clog2(NBIN)
) (
  input  char_e                   char_i,
  input  logic [BIN_W-1:0]        bin_i,
  input  logic [NBIN*RATE_W-1:0]  user_rates_i,
  output logic [RATE_W-1:0]       rate_o
);
  logic [RATE_W-1:0] b1;

  assign b1 = RATE_W'(bin_i) + RATE_W'(1);

  always_comb begin
    unique case (char_i)
      CH_INV_A: rate_o = b1;
      CH_INV_B: rate_o = b1 * b1;
      CH_USER:  rate_o = user_rates_i[int'(bin_i)*RATE_W +: RATE_W];
      default:  rate_o = RATE_W'(1);
    endcase
  end
endmodule

// File: rtl/ovc_phase_timer.sv
module ovc_phase_timer #(
  parameter int ACC_W  = 16,
  parameter int DLY_W  = 12,
  parameter int RATE_W = 8,
  parameter int DECAY  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pu_i,
  input  logic              blk_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [ACC_W-1:0]  thr_i,
  input  logic              decay_en_i,
  input  logic              inst_clr_i,
  input  logic [DLY_W-1:0]  rst_dly_i,
  input  logic [DLY_W-1:0]  min_op_i,
  input  logic [DLY_W-1:0]  follow_i,
  output logic              trip_o
);
  logic [ACC_W-1:0] acc_q, acc_inc;
  logic [ACC_W:0]   acc_sum;
  logic [DLY_W-1:0] pu_cnt_q, pu_inc, fol_cnt_q, rst_cnt_q, rst_inc;
  logic             trip_q, done;

  assign acc_sum = {1'b0, acc_q} + (ACC_W+1)'(rate_i);
  assign acc_inc = acc_sum[ACC_W] ? '1 : acc_sum[ACC_W-1:0];
  assign pu_inc  = (pu_cnt_q == '1) ? pu_cnt_q : pu_cnt_q + 1'b1;
  assign rst_inc = rst_cnt_q + 1'b1;
  assign done    = (acc_inc >= thr_i) && (pu_inc >= min_op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      pu_cnt_q  <= '0;
      fol_cnt_q <= '0;
      rst_cnt_q <= '0;
      trip_q    <= 1'b0;
    end else if (tick_i) begin
      if (pu_i) begin
        acc_q     <= acc_inc;
        pu_cnt_q  <= pu_inc;
        rst_cnt_q <= '0;
        if (done) begin
          if (fol_cnt_q == follow_i) trip_q <= 1'b1;
          else                       fol_cnt_q <= fol_cnt_q + 1'b1;
        end
      end else begin
        trip_q    <= 1'b0;
        fol_cnt_q <= '0;
        pu_cnt_q  <= '0;
        if (blk_i || inst_clr_i) begin
          acc_q     <= '0;
          rst_cnt_q <= '0;
        end else if (decay_en_i) begin
          acc_q     <= (acc_q > ACC_W'(DECAY)) ? acc_q - ACC_W'(DECAY) : '0;
          rst_cnt_q <= '0;
        end else if (rst_inc >= rst_dly_i) begin
          acc_q     <= '0;
          rst_cnt_q <= '0;
        end else begin
          rst_cnt_q <= rst_inc;
        end
      end
    end
  end

  // drop at once when the phase leaves pickup or is blocked
  assign trip_o = trip_q & pu_i;
endmodule

// File: rtl/ovc_trip_element.sv
module ovc_trip_element import ovc_pkg::*; #(
  parameter int N_PH       = 3,
  parameter int CUR_W      = 12,
  parameter int NBIN       = 8,
  parameter int RATE_W     = 8,
  parameter int MULT_W     = 8,
  parameter int DLY_W      = 12,
  parameter int FS_SHIFT   = 6,
  parameter int DECAY_STEP = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic [N_PH*CUR_W-1:0]  cur_i,
  input  logic [N_PH-1:0]        inrush_i,
  input  logic                   inhibit_i,
  input  logic                   enable_i,
  input  logic                   inrush_blk_i,
  input  logic [1:0]             char_sel_i,
  input  logic                   rst_mode_i,
  input  logic [CUR_W-1:0]       pickup_lvl_i,
  input  logic [MULT_W-1:0]      tmult_i,
  input  logic [DLY_W-1:0]       dt_delay_i,
  input  logic [DLY_W-1:0]       rst_delay_i,
  input  logic [DLY_W-1:0]       min_op_i,
  input  logic [DLY_W-1:0]       follow_i,
  input  logic [NBIN*RATE_W-1:0] user_rates_i,
  output logic [N_PH-1:0]        pickup_o,
  output logic [N_PH-1:0]        trip_o,
  output logic                   gen_pickup_o
);
  localparam int BIN_W = $clog2(NBIN);
  localparam int INV_W = MULT_W + FS_SHIFT;
  localparam int ACC_W = ((INV_W > DLY_W) ? INV_W : DLY_W) + 2;

  char_e            ch;
  logic             decay_en, inst_clr;
  logic [ACC_W-1:0] thr;

  assign ch       = char_e'(char_sel_i);
  assign decay_en = (rst_mode_i == RM_DECAY) && (ch == CH_INV_B);
  assign inst_clr = (rst_mode_i == RM_DECAY) && (ch != CH_INV_B);
  assign thr      = (ch == CH_DEF) ? ACC_W'(dt_delay_i)
                                   : ACC_W'(tmult_i) << FS_SHIFT;

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    logic              above, blk;
    logic [BIN_W-1:0]  bin;
    logic [RATE_W-1:0] rate;

    ovc_ratio_bin #(.CUR_W(CUR_W), .NBIN(NBIN)) u_bin (
      .cur_i   (cur_i[p*CUR_W +: CUR_W]),
      .lvl_i   (pickup_lvl_i),
      .above_o (above),
      .bin_o   (bin)
    );

    ovc_rate_lut #(.NBIN(NBIN), .RATE_W(RATE_W)) u_lut (
      .char_i       (ch),
      .bin_i        (bin),
      .user_rates_i (user_rates_i),
      .rate_o       (rate)
    );

    assign blk         = ~enable_i | inhibit_i | (inrush_blk_i & inrush_i[p]);
    assign pickup_o[p] = above & ~blk;

    ovc_phase_timer #(
      .ACC_W(ACC_W), .DLY_W(DLY_W), .RATE_W(RATE_W), .DECAY(DECAY_STEP)
    ) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .pu_i       (pickup_o[p]),
      .blk_i      (blk),
      .rate_i     (rate),
      .thr_i      (thr),
      .decay_en_i (decay_en),
      .inst_clr_i (inst_clr),
      .rst_dly_i  (rst_delay_i),
      .min_op_i   (min_op_i),
      .follow_i   (follow_i),
      .trip_o     (trip_o[p])
    );
  end

  assign gen_pickup_o = |pickup_o;
endmodule

// File: rtl/ovc_trip_sva.sv
module ovc_trip_sva #(
  parameter int N_PH = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            inhibit_i,
  input logic            enable_i,
  input logic            inrush_blk_i,
  input logic [N_PH-1:0] inrush_i,
  input logic [N_PH-1:0] pickup_o,
  input logic [N_PH-1:0] trip_o,
  input logic            gen_pickup_o
);
  a_r8_inhibit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> (pickup_o == '0 && trip_o == '0 && !gen_pickup_o));

  a_r10_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (pickup_o == '0 && trip_o == '0 && !gen_pickup_o));

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    a_r9_inrush_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inrush_blk_i && inrush_i[p]) |-> (!pickup_o[p] && !trip_o[p]));

    a_r11_trip_needs_pickup: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip_o[p] |-> pickup_o[p]);

    a_r11_trip_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !pickup_o[p]) |=> !trip_o[p]);
  end
endmodule

bind ovc_trip_element ovc_trip_sva #(.N_PH(N_PH)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .inhibit_i    (inhibit_i),
  .enable_i     (enable_i),
  .inrush_blk_i (inrush_blk_i),
  .inrush_i     (inrush_i),
  .pickup_o     (pickup_o),
  .trip_o       (trip_o),
  .gen_pickup_o (gen_pickup_o)
);

// File: tb/tb_ovc_trip_element.sv
`timescale 1ns/1ps
module tb_ovc_trip_element;
  localparam int LVL = 100;
  localparam int UR[8] = '{1, 2, 3, 5, 8, 13, 21, 34};

  logic        clk = 0, rst_ni = 0, tick_i = 0;
  logic [11:0] c0 = 0, c1 = 0, c2 = 0;
  logic [35:0] cur_i;
  logic [2:0]  inrush_i = 0;
  logic        inhibit_i = 0, enable_i = 1, inrush_blk_i = 0;
  logic [1:0]  char_sel_i = 0;
  logic        rst_mode_i = 0;
  logic [11:0] pickup_lvl_i = LVL[11:0];
  logic [7:0]  tmult_i = 1;
  logic [11:0] dt_delay_i = 1, rst_delay_i = 0, min_op_i = 0, follow_i = 0;
  logic [63:0] user_rates_i;
  logic [2:0]  pickup_o, trip_o;
  logic        gen_pickup_o;

  int checks = 0, errors = 0;
  bit done = 0;

  assign cur_i        = {c2, c1, c0};
  assign user_rates_i = {8'd34, 8'd21, 8'd13, 8'd8, 8'd5, 8'd3, 8'd2, 8'd1};

  always #2.5 clk = ~clk;

  ovc_trip_element dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .cur_i(cur_i),
    .inrush_i(inrush_i), .inhibit_i(inhibit_i), .enable_i(enable_i),
    .inrush_blk_i(inrush_blk_i), .char_sel_i(char_sel_i),
    .rst_mode_i(rst_mode_i), .pickup_lvl_i(pickup_lvl_i), .tmult_i(tmult_i),
    .dt_delay_i(dt_delay_i), .rst_delay_i(rst_delay_i), .min_op_i(min_op_i),
    .follow_i(follow_i), .user_rates_i(user_rates_i), .pickup_o(pickup_o),
    .trip_o(trip_o), .gen_pickup_o(gen_pickup_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_i = 1;
    @(negedge clk) tick_i = 0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic clear_state();
    @(negedge clk) inhibit_i = 1;
    do_tick();
    inhibit_i = 0;
  endtask

  task automatic count_trip(output int n);
    n = -1;
    for (int i = 1; i <= 600; i++) begin
      do_tick();
      if (trip_o[0]) begin
        n = i;
        break;
      end
    end
  endtask

  function automatic int exp_ticks(int ch, int cur, int tm, int dly, int mn, int fol);
    int b, rate, thr, k;
    if (ch == 3) begin
      thr = dly; rate = 1;
    end else begin
      b = cur / LVL;
      if (b > 8) b = 8;
      b = b - 1;
      rate = (ch == 0) ? b + 1 : (ch == 1) ? (b + 1) * (b + 1) : UR[b];
      thr = tm * 64;
    end
    k = (thr + rate - 1) / rate;
    if (k < mn) k = mn;
    if (k < 1) k = 1;
    return k + fol;
  endfunction

  task automatic run_case(input string req, input int ch, input int cur,
                          input int tm, input int dly, input int mn, input int fol);
    int n;
    @(negedge clk);
    char_sel_i = ch[1:0]; tmult_i = tm[7:0]; dt_delay_i = dly[11:0];
    min_op_i = mn[11:0]; follow_i = fol[11:0]; c0 = cur[11:0];
    clear_state();
    count_trip(n);
    chk(n == exp_ticks(ch, cur, tm, dly, mn, fol), req, n, exp_ticks(ch, cur, tm, dly, mn, fol));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    chk(pickup_o == 0 && trip_o == 0 && !gen_pickup_o, "R11 reset", {trip_o, pickup_o}, 0);

    // R1 boundary and general pickup
    c0 = 100; #1;
    chk(pickup_o[0] == 0, "R1 equal level", pickup_o[0], 0);
    c0 = 101; #1;
    chk(pickup_o == 3'b001 && gen_pickup_o, "R1 above level", pickup_o, 1);
    c0 = 0; c2 = 500; #1;
    chk(pickup_o == 3'b100 && gen_pickup_o, "R1 general pickup", {gen_pickup_o, pickup_o}, 12);
    c2 = 0; #1;
    chk(!gen_pickup_o, "R1 general idle", gen_pickup_o, 0);

    // R2 / R3 sweep over inverse curves
    foreach (UR[i]) ;
    for (int ch = 0; ch < 3; ch++)
      for (int tm = 1; tm <= 2; tm++) begin
        run_case("R2 curve 150", ch, 150, tm, 1, 0, 0);
        run_case("R2 curve 250", ch, 250, tm, 1, 0, 0);
        run_case("R2 curve 450", ch, 450, tm, 1, 0, 0);
        run_case("R2 curve 900", ch, 900, tm, 1, 0, 0);
      end

    // R3 definite time ignores multiplier
    run_case("R3 definite d1", 3, 150, 9, 1, 0, 0);
    run_case("R3 definite tm1", 3, 150, 1, 17, 0, 0);
    run_case("R3 definite tm9", 3, 900, 9, 17, 0, 0);

    // R4 floor vs curve, R5 follower
    run_case("R4 floor governs", 1, 900, 1, 1, 10, 0);
    run_case("R4 curve governs", 0, 150, 1, 1, 10, 0);
    run_case("R5 follower", 1, 900, 1, 1, 0, 5);
    run_case("R5 floor plus follower", 1, 900, 1, 1, 10, 5);
    run_case("R5 curve plus follower", 0, 150, 1, 1, 10, 3);

    // R11 hold and drop
    run_case("R11 setup", 3, 150, 1, 4, 0, 0);
    tick_n(3);
    chk(trip_o[0] == 1, "R11 held", trip_o[0], 1);
    @(negedge clk) inhibit_i = 1; #1;
    chk(trip_o[0] == 0 && pickup_o == 0, "R8 same cycle", trip_o[0], 0);
    @(negedge clk) inhibit_i = 0; #1;
    c0 = 50; #1;
    chk(trip_o[0] == 0, "R11 drop at once", trip_o[0], 0);
    do_tick();
    c0 = 150; #1;
    chk(trip_o[0] == 0, "R11 stays low after tick", trip_o[0], 0);

    // R8 inhibit tick clears timing
    @(negedge clk); dt_delay_i = 20; clear_state();
    tick_n(15);
    @(negedge clk) inhibit_i = 1;
    do_tick();
    inhibit_i = 0;
    count_trip(n);
    chk(n == 20, "R8 timing cleared", n, 20);

    // R10 enable
    @(negedge clk) enable_i = 0; c0 = 500; #1;
    chk(pickup_o == 0 && trip_o == 0, "R10 disabled", pickup_o, 0);
    @(negedge clk) enable_i = 1;

    // R9 inrush
    @(negedge clk) c0 = 500; c1 = 500; inrush_i = 3'b001; inrush_blk_i = 1; #1;
    chk(pickup_o == 3'b010, "R9 inrush blocks", pickup_o, 2);
    @(negedge clk) inrush_blk_i = 0; #1;
    chk(pickup_o == 3'b011, "R9 inrush ignored", pickup_o, 3);
    @(negedge clk) inrush_i = 0; c1 = 0;

    // R6 definite reset
    @(negedge clk); char_sel_i = 3; dt_delay_i = 50; rst_mode_i = 0; rst_delay_i = 4;
    min_op_i = 0; follow_i = 0; c0 = 150; clear_state();
    tick_n(20); c0 = 50; tick_n(3); c0 = 150;
    count_trip(n);
    chk(n == 30, "R6 held", n, 30);
    clear_state();
    tick_n(20); c0 = 50; tick_n(4); c0 = 150;
    count_trip(n);
    chk(n == 50, "R6 cleared", n, 50);

    // R7 decaying reset
    @(negedge clk); char_sel_i = 1; tmult_i = 1; rst_mode_i = 1; c0 = 150; clear_state();
    tick_n(40); c0 = 50; tick_n(5); c0 = 150;
    count_trip(n);
    chk(n == 34, "R7 decay", n, 34);
    clear_state();
    tick_n(40); c0 = 50; tick_n(25); c0 = 150;
    count_trip(n);
    chk(n == 64, "R7 decay floor", n, 64);
    @(negedge clk); char_sel_i = 0; clear_state();
    tick_n(40); c0 = 50; tick_n(1); c0 = 150;
    count_trip(n);
    chk(n == 64, "R7 instant clear", n, 64);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule